// File: doc/BRIEF.md
# Transparent Serial Frame Receiver

This block turns a synchronous serial bit stream into bytes without imposing any framing of its own. One bit is taken per cycle in which `bit_valid` is high. After reset, or after it is told to resynchronize, the receiver stays in a hunt state and discards every incoming bit. It leaves that state when it gets an external sync pulse or when it finds a programmable 8- or 16-bit sync pattern. Once locked, it packs bits into bytes and can mirror their bit order. It hands each byte to a single-entry output register that uses a valid/ready handshake.

Bytes are grouped into buffers of a fixed length. The block does not manage storage; a single `buf_avail` input tells it whether a buffer can be opened. At the end of every buffer it pulses a full indication, and it may raise an interrupt pulse with it. It always runs a CRC check over the buffer's raw bits and reports the result, even in systems that ignore it. When no buffer is available it raises busy. An overrun, meaning a completed byte that meets a still-occupied output register, counts as an error and sends the receiver back to hunt.

Top module: `tsr_rx`

## Requirements
- R1: After reset `hunting` is 1, and `out_valid`, `buf_full`, `buf_irq`, `crc_err`, `busy` and `overrun` are all 0.
- R2: In pattern mode (`cfg_pattern_mode`=1) the receiver passes no data while hunting. It locks once the bits received since hunt entry end with the sync word: `cfg_pattern[7:0]` when `cfg_sync_long`=0, or all 16 bits when it is 1. The earliest received bit is compared with the word's MSB. The sync word is not output, and the next bit starts the first byte.
- R3: In pulse mode (`cfg_pattern_mode`=0) bits are ignored while hunting. A `sync_pulse` cycle locks the receiver, and the first data bit is the first `bit_valid` in a later cycle.
- R4: With `cfg_bit_rev`=0 the first received bit of a byte lands in `out_byte[7]`. With `cfg_bit_rev`=1 it lands in `out_byte[0]`.
- R5: A byte appears on `out_valid`/`out_byte` one cycle after its eighth bit and is held unchanged until a cycle with `out_ready`=1.
- R6: The byte that completes a buffer of `BUF_LEN` delivered bytes comes out with a one-cycle `buf_full` pulse. `buf_irq` pulses with it if `buf_irq_en` is 1 in that byte's completing cycle.
- R7: The CRC is a shift register that starts at zero for each buffer. Bits enter most significant first, in arrival order and before any reversal. The polynomial is 0x1021 (16-bit) when `cfg_crc_wide`=0 and 0x04C11DB7 (32-bit) when it is 1. `crc_err` shows whether the register was nonzero after the buffer's last bit, is updated together with `buf_full`, and is held until the next `buf_full`.
- R8: A byte that completes while no buffer is open and `buf_avail`=0 raises a one-cycle `busy` pulse. The byte is discarded, is not counted toward the buffer length and does not enter its CRC.
- R9: A byte that completes while `out_valid`=1 and `out_ready`=0 is lost. It raises a one-cycle `overrun` pulse and returns the receiver to hunt, discarding the partial buffer; the byte already held stays on the output.
- R10: `hunt_cmd` returns the receiver to hunt in the next cycle. The partial byte and buffer are discarded, and so is any byte completing in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | A serial bit is present this cycle |
| bit_in | input | 1 | Serial data bit |
| sync_pulse | input | 1 | External synchronization strobe (pulse mode) |
| hunt_cmd | input | 1 | Command to re-enter hunt |
| cfg_pattern_mode | input | 1 | 1: lock on sync word, 0: lock on sync pulse |
| cfg_sync_long | input | 1 | 1: 16-bit sync word, 0: 8-bit sync word |
| cfg_pattern | input | SYNC_W | Sync word, MSB compared with earliest bit |
| cfg_bit_rev | input | 1 | Mirror the bit order of each byte |
| cfg_crc_wide | input | 1 | 0: 16-bit CRC, 1: 32-bit CRC |
| buf_avail | input | 1 | A buffer can be opened |
| buf_irq_en | input | 1 | Interrupt request for the buffer being closed |
| out_ready | input | 1 | Consumer takes the byte this cycle |
| out_valid | output | 1 | Output byte valid |
| out_byte | output | BYTE_W | Received byte |
| buf_full | output | 1 | Pulse: current byte closes a buffer |
| buf_irq | output | 1 | Pulse: buffer-closed interrupt |
| crc_err | output | 1 | CRC result of the last closed buffer |
| busy | output | 1 | Pulse: byte dropped for lack of a buffer |
| overrun | output | 1 | Pulse: byte lost to backpressure |
| hunting | output | 1 | Receiver is in hunt |

## Verification
Buffers of random bytes are sent, some with a correct appended CRC and some with one bit flipped. The bit-order option and the polynomial are randomized per buffer and each bit comes with random idle gaps, so that an error in bit order, bit-valid gating or residue selection shows up as a mismatch. Lock is tried with noise that holds a short-pattern match inside a long-pattern hunt, which separates the two pattern lengths. Pulse lock is tried after pre-sync bits. Directed cases withhold the buffer, stall the consumer and issue a hunt command in mid-byte, and a clean buffer follows each one to show that byte alignment and CRC state were restored.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

   typedef enum logic {
      HS_HUNT   = 1'b0,
      HS_LOCKED = 1'b1
   } hunt_st_t;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/tsr_hunt.sv
module tsr_hunt
   import tsr_pkg::*;
#(
   parameter int unsigned SYNC_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_valid,
   input  logic              bit_in,
   input  logic              sync_pulse,
   input  logic              hunt_req,
   input  logic              cfg_pattern_mode,
   input  logic              cfg_sync_long,
   input  logic [SYNC_W-1:0] cfg_pattern,
   output logic              synced
);

   localparam int unsigned SHORT_W = SYNC_W / 2;
   localparam int unsigned FILL_W  = $clog2(SYNC_W + 1);

   if ((SYNC_W < 4) || ((SYNC_W % 2) != 0)) begin : g_bad_sync_w
      $error("tsr_hunt: SYNC_W must be even and at least 4");
   end

   hunt_st_t            state_q;
   logic [SYNC_W-1:0]   hist_q;
   logic [SYNC_W-1:0]   hist_n;
   logic [FILL_W-1:0]   fill_q;
   logic                match_long;
   logic                match_short;
   logic                pattern_hit;

   always_comb begin
      hist_n      = {hist_q[SYNC_W-2:0], bit_in};
      match_long  = (fill_q >= FILL_W'(SYNC_W - 1)) && (hist_n == cfg_pattern);
      match_short = (fill_q >= FILL_W'(SHORT_W - 1)) &&
                    (hist_n[SHORT_W-1:0] == cfg_pattern[SHORT_W-1:0]);
      pattern_hit = bit_valid && (cfg_sync_long ? match_long : match_short);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || hunt_req) begin
         state_q <= HS_HUNT;
         hist_q  <= '0;
         fill_q  <= '0;
      end else if (state_q == HS_HUNT) begin
         if (cfg_pattern_mode) begin
            if (bit_valid) begin
               hist_q <= hist_n;
               if (fill_q != FILL_W'(SYNC_W)) begin
                  fill_q <= fill_q + 1'b1;
               end
            end
            if (pattern_hit) begin
               state_q <= HS_LOCKED;
            end
         end else if (sync_pulse) begin
            state_q <= HS_LOCKED;
         end
      end
   end

   assign synced = (state_q == HS_LOCKED);

   AST_HUNT_ON_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      hunt_req |=> !synced);  // R10
   AST_LOCK_NEEDS_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(synced) |-> $past(cfg_pattern_mode ? bit_valid : sync_pulse));  // R3

endmodule

// File: rtl/tsr_deser.sv
module tsr_deser #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              bit_valid,
   input  logic              bit_in,
   output logic              byte_done,
   output logic [BYTE_W-1:0] byte_word
);

   localparam int unsigned CNT_W = $clog2(BYTE_W);

   if (BYTE_W < 2) begin : g_bad_byte_w
      $error("tsr_deser: BYTE_W must be at least 2");
   end

   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-2:0] shift_q;

   assign byte_word = {shift_q, bit_in};
   assign byte_done = active && bit_valid && (cnt_q == CNT_W'(BYTE_W - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || !active) begin
         cnt_q   <= '0;
         shift_q <= '0;
      end else if (bit_valid) begin
         shift_q <= byte_word[BYTE_W-2:0];
         cnt_q   <= byte_done ? '0 : cnt_q + 1'b1;
      end
   end

   AST_BITS_ONLY_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (cnt_q == '0));  // R10

endmodule

// File: rtl/tsr_crc.sv
module tsr_crc #(
   parameter int unsigned     NARROW_W    = 16,
   parameter logic [63:0]     NARROW_POLY = 64'h1021,
   parameter int unsigned     WIDE_W      = 32,
   parameter logic [63:0]     WIDE_POLY   = 64'h04C1_1DB7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   input  logic bit_in,
   input  logic sel_wide,
   output logic resid_zero
);

   if ((NARROW_W < 2) || (WIDE_W < 2) || (NARROW_W > 64) || (WIDE_W > 64)) begin : g_bad_crc_w
      $error("tsr_crc: CRC widths must lie between 2 and 64");
   end

   logic [1:0] zero_v;

   for (genvar v = 0; v < 2; v++) begin : g_var
      localparam int unsigned   W = (v == 0) ? NARROW_W : WIDE_W;
      localparam logic [63:0]   P64 = (v == 0) ? NARROW_POLY : WIDE_POLY;
      localparam logic [W-1:0]  P = P64[W-1:0];

      logic [W-1:0] crc_q;
      logic [W-1:0] crc_n;
      logic         fb;

      always_comb begin
         fb    = crc_q[W-1] ^ bit_in;
         crc_n = en ? ({crc_q[W-2:0], 1'b0} ^ (fb ? P : '0)) : crc_q;
      end

      assign zero_v[v] = (crc_n == '0);

      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            crc_q <= '0;
         end else begin
            crc_q <= crc_n;
         end
      end

      AST_CRC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
         clr |=> (crc_q == '0));  // R7
   end

   assign resid_zero = sel_wide ? zero_v[1] : zero_v[0];

endmodule

// File: rtl/tsr_rx.sv
module tsr_rx
   import tsr_pkg::*;
#(
   parameter int unsigned BUF_LEN     = 6,
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned SYNC_W      = 16,
   parameter int unsigned NARROW_W    = 16,
   parameter logic [63:0] NARROW_POLY = 64'h1021,
   parameter int unsigned WIDE_W      = 32,
   parameter logic [63:0] WIDE_POLY   = 64'h04C1_1DB7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_valid,
   input  logic              bit_in,
   input  logic              sync_pulse,
   input  logic              hunt_cmd,
   input  logic              cfg_pattern_mode,
   input  logic              cfg_sync_long,
   input  logic [SYNC_W-1:0] cfg_pattern,
   input  logic              cfg_bit_rev,
   input  logic              cfg_crc_wide,
   input  logic              buf_avail,
   input  logic              buf_irq_en,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [BYTE_W-1:0] out_byte,
   output logic              buf_full,
   output logic              buf_irq,
   output logic              crc_err,
   output logic              busy,
   output logic              overrun,
   output logic              hunting
);

   localparam int unsigned CNT_W = $clog2(BUF_LEN);
   localparam int unsigned CRC_MAX_W = max_u(NARROW_W, WIDE_W);

   if (BUF_LEN < 2) begin : g_bad_buf_len
      $error("tsr_rx: BUF_LEN must be at least 2");
   end
   if (CRC_MAX_W > 64) begin : g_bad_crc_max
      $error("tsr_rx: CRC width above 64");
   end

   logic              synced;
   logic              hunt_req;
   logic              byte_done;
   logic [BYTE_W-1:0] byte_word;
   logic [BYTE_W-1:0] byte_rev;
   logic              resid_zero;

   logic              byte_ev;
   logic              busy_now;
   logic              ovr_now;
   logic              take;
   logic              last;
   logic              crc_clr;
   logic [CNT_W-1:0]  cnt_q;

   tsr_hunt #(.SYNC_W(SYNC_W)) hunt_i (
      .clk              (clk),
      .rst_n            (rst_n),
      .bit_valid        (bit_valid),
      .bit_in           (bit_in),
      .sync_pulse       (sync_pulse),
      .hunt_req         (hunt_req),
      .cfg_pattern_mode (cfg_pattern_mode),
      .cfg_sync_long    (cfg_sync_long),
      .cfg_pattern      (cfg_pattern),
      .synced           (synced)
   );

   tsr_deser #(.BYTE_W(BYTE_W)) deser_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (synced),
      .bit_valid (bit_valid),
      .bit_in    (bit_in),
      .byte_done (byte_done),
      .byte_word (byte_word)
   );

   tsr_crc #(
      .NARROW_W    (NARROW_W),
      .NARROW_POLY (NARROW_POLY),
      .WIDE_W      (WIDE_W),
      .WIDE_POLY   (WIDE_POLY)
   ) crc_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (crc_clr),
      .en         (synced && bit_valid),
      .bit_in     (bit_in),
      .sel_wide   (cfg_crc_wide),
      .resid_zero (resid_zero)
   );

   for (genvar i = 0; i < BYTE_W; i++) begin : g_rev
      assign byte_rev[i] = byte_word[BYTE_W-1-i];
   end

   always_comb begin
      byte_ev  = byte_done && !hunt_cmd;
      busy_now = byte_ev && (cnt_q == '0) && !buf_avail;
      ovr_now  = byte_ev && !busy_now && out_valid && !out_ready;
      take     = byte_ev && !busy_now && !ovr_now;
      last     = take && (cnt_q == CNT_W'(BUF_LEN - 1));
      hunt_req = hunt_cmd || ovr_now;
      crc_clr  = !synced || last || busy_now;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_byte  <= '0;
         buf_full  <= 1'b0;
         buf_irq   <= 1'b0;
         crc_err   <= 1'b0;
         busy      <= 1'b0;
         overrun   <= 1'b0;
         cnt_q     <= '0;
      end else begin
         buf_full <= last;
         buf_irq  <= last && buf_irq_en;
         busy     <= busy_now;
         overrun  <= ovr_now;
         if (last) begin
            crc_err <= !resid_zero;
         end
         if (take) begin
            out_valid <= 1'b1;
            out_byte  <= cfg_bit_rev ? byte_rev : byte_word;
         end else if (out_ready) begin
            out_valid <= 1'b0;
         end
         if (!synced || hunt_req || last) begin
            cnt_q <= '0;
         end else if (take) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign hunting = !synced;

   AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));  // R5
   AST_DATA_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(synced));  // R2
   AST_IRQ_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      buf_irq |-> buf_full);  // R6
   AST_FULL_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      buf_full |-> out_valid);  // R6
   AST_OVERRUN_HUNTS: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> hunting);  // R9
   AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !$rose(out_valid));  // R8
   AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({buf_full, busy, overrun}));  // R8
   AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CNT_W'(BUF_LEN));  // R6

endmodule

// File: tb/tsr_rx_tb_top.sv
`timescale 1ns/1ps
module tsr_rx_tb_top;

   localparam int unsigned BUF_LEN = 6;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bit_valid, bit_in, sync_pulse, hunt_cmd;
   logic        cfg_pattern_mode, cfg_sync_long, cfg_bit_rev, cfg_crc_wide;
   logic [15:0] cfg_pattern;
   logic        buf_avail, buf_irq_en, out_ready;
   logic        out_valid, buf_full, buf_irq, crc_err, busy, overrun, hunting;
   logic [7:0]  out_byte;

   int checks = 0;
   int fails  = 0;
   int busy_cnt = 0;
   int ovr_cnt  = 0;
   bit done = 0;

   logic [7:0] exp_q[$];
   logic [1:0] full_q[$];
   logic [7:0] bufb[BUF_LEN];

   always #2 clk = ~clk;

   tsr_rx #(.BUF_LEN(BUF_LEN)) dut_i (
      .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
      .sync_pulse(sync_pulse), .hunt_cmd(hunt_cmd),
      .cfg_pattern_mode(cfg_pattern_mode), .cfg_sync_long(cfg_sync_long),
      .cfg_pattern(cfg_pattern), .cfg_bit_rev(cfg_bit_rev),
      .cfg_crc_wide(cfg_crc_wide), .buf_avail(buf_avail),
      .buf_irq_en(buf_irq_en), .out_valid(out_valid), .out_ready(out_ready),
      .out_byte(out_byte), .buf_full(buf_full), .buf_irq(buf_irq),
      .crc_err(crc_err), .busy(busy), .overrun(overrun), .hunting(hunting)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   function automatic logic [7:0] mirror(input logic [7:0] b);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = b[7-i];
      return r;
   endfunction

   function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b,
                                            input bit wide);
      logic fb;
      for (int i = 7; i >= 0; i--) begin
         if (wide) begin
            fb = c[31] ^ b[i];
            c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
         end else begin
            fb = c[15] ^ b[i];
            c  = {16'h0, c[14:0], 1'b0} ^ (fb ? 32'h1021 : 32'h0);
         end
      end
      return c;
   endfunction

   // Monitor: outputs are registers, sampled at the falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2/R5 unexpected byte", {24'h0, out_byte}, 32'h0);
            end else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               chk(out_byte == e, "R4/R5 byte value", {24'h0, out_byte}, {24'h0, e});
            end
         end
         if (buf_full) full_q.push_back({crc_err, buf_irq});
         if (busy) busy_cnt++;
         if (overrun) ovr_cnt++;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk);
      bit_valid = 1'b1;
      bit_in    = b;
      @(negedge clk);
      bit_valid = 1'b0;
      bit_in    = $urandom_range(0, 1);
      repeat ($urandom_range(0, 2)) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit expect_out);
      if (expect_out) exp_q.push_back(cfg_bit_rev ? mirror(b) : b);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
   endtask

   task automatic pulse_hunt();
      @(negedge clk);
      hunt_cmd = 1'b1;
      @(negedge clk);
      hunt_cmd = 1'b0;
   endtask

   task automatic pulse_sync();
      @(negedge clk);
      sync_pulse = 1'b1;
      @(negedge clk);
      sync_pulse = 1'b0;
   endtask

   // Builds one buffer; a clean buffer ends with its own CRC so the residue is zero
   task automatic send_buffer(input bit wide, input bit corrupt, input bit irq,
                              input string req);
      int          npay;
      logic [31:0] c;
      logic [1:0]  got;
      bit          exp_err;
      npay = wide ? BUF_LEN - 4 : BUF_LEN - 2;
      c = 32'h0;
      for (int i = 0; i < npay; i++) begin
         bufb[i] = 8'($urandom);
         c = crc_byte(c, bufb[i], wide);
      end
      if (wide) begin
         for (int i = 0; i < 4; i++) bufb[npay+i] = c[31-8*i -: 8];
      end else begin
         bufb[npay]   = c[15:8];
         bufb[npay+1] = c[7:0];
      end
      if (corrupt) begin
         int k;
         k = $urandom_range(0, BUF_LEN - 1);
         bufb[k][$urandom_range(0, 7)] ^= 1'b1;
      end
      c = 32'h0;
      for (int i = 0; i < BUF_LEN; i++) c = crc_byte(c, bufb[i], wide);
      exp_err = (c != 32'h0);
      cfg_crc_wide = wide;
      buf_irq_en   = irq;
      for (int i = 0; i < BUF_LEN; i++) send_byte(bufb[i], 1'b1);
      idle(3);
      chk(full_q.size() == 1, {req, " R6 one buffer-full pulse"}, full_q.size(), 1);
      if (full_q.size() > 0) begin
         got = full_q.pop_front();
         chk(got[1] == exp_err, {req, " R7 crc result"}, got[1], exp_err);
         chk(got[0] == irq, {req, " R6 interrupt pulse"}, got[0], irq);
      end
      full_q.delete();
   endtask

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; bit_valid = 0; bit_in = 0; sync_pulse = 0; hunt_cmd = 0;
      cfg_pattern_mode = 1; cfg_sync_long = 0; cfg_pattern = 16'h007E;
      cfg_bit_rev = 0; cfg_crc_wide = 0; buf_avail = 1; buf_irq_en = 0; out_ready = 1;
      idle(5);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk(hunting == 1'b1, "R1 hunting after reset", hunting, 1);
      chk({out_valid, buf_full, buf_irq, crc_err, busy, overrun} == 6'b0,
          "R1 outputs idle after reset",
          {out_valid, buf_full, buf_irq, crc_err, busy, overrun}, 0);

      // R2: 8-bit pattern lock after noise
      send_byte(8'hFF, 1'b0);
      send_byte(8'hFF, 1'b0);
      idle(2);
      chk(hunting == 1'b1, "R2 no lock on noise", hunting, 1);
      send_byte(8'h7E, 1'b0);
      idle(1);
      chk(hunting == 1'b0, "R2 lock on short pattern", hunting, 0);
      send_buffer(1'b0, 1'b0, 1'b1, "R2 first buffer");

      // R4 R7 R6: random buffers with random options
      for (int k = 0; k < 14; k++) begin
         cfg_bit_rev = $urandom_range(0, 1);
         send_buffer($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                     "R4/R7 random buffer");
      end
      cfg_bit_rev = 0;

      // R10 and R2: 16-bit pattern; short match alone must not lock
      pulse_hunt();
      idle(1);
      chk(hunting == 1'b1, "R10 hunt command", hunting, 1);
      cfg_sync_long = 1; cfg_pattern = 16'hA5C3;
      send_byte(8'hC3, 1'b0);
      idle(2);
      chk(hunting == 1'b1, "R2 long mode ignores short match", hunting, 1);
      send_byte(8'hA5, 1'b0);
      send_byte(8'hC3, 1'b0);
      idle(1);
      chk(hunting == 1'b0, "R2 lock on long pattern", hunting, 0);
      send_buffer(1'b1, 1'b0, 1'b0, "R2 long buffer");

      // R3: pulse lock
      pulse_hunt();
      cfg_pattern_mode = 0;
      send_byte(8'h12, 1'b0);
      idle(2);
      chk(hunting == 1'b1, "R3 bits ignored before pulse", hunting, 1);
      chk(exp_q.size() == 0, "R3 no output before pulse", exp_q.size(), 0);
      pulse_sync();
      chk(hunting == 1'b0, "R3 lock on pulse", hunting, 0);
      send_buffer(1'b0, 1'b0, 1'b0, "R3 pulse buffer");

      // R8: busy drops a byte that does not count and does not enter the CRC
      buf_avail = 0;
      send_byte(8'h55, 1'b0);
      idle(2);
      chk(busy_cnt == 1, "R8 busy pulse", busy_cnt, 1);
      chk(hunting == 1'b0, "R8 still locked", hunting, 0);
      buf_avail = 1;
      send_buffer(1'b0, 1'b0, 1'b1, "R8 after busy");

      // R9: overrun
      out_ready = 0;
      send_byte(8'h3C, 1'b1);
      send_byte(8'h99, 1'b0);
      idle(2);
      chk(ovr_cnt == 1, "R9 overrun pulse", ovr_cnt, 1);
      chk(hunting == 1'b1, "R9 overrun returns to hunt", hunting, 1);
      chk(out_valid == 1'b1 && out_byte == 8'h3C, "R9 held byte kept",
          {23'h0, out_valid, out_byte}, 32'h13C);
      out_ready = 1;
      idle(2);
      chk(exp_q.size() == 0, "R5 held byte delivered", exp_q.size(), 0);

      // R10: hunt command in mid-byte discards the partial byte
      pulse_sync();
      for (int i = 0; i < 4; i++) send_bit(1'b1);
      pulse_hunt();
      idle(1);
      chk(hunting == 1'b1, "R10 hunt in mid-byte", hunting, 1);
      pulse_sync();
      send_buffer(1'b1, 1'b1, 1'b1, "R10 realigned buffer");

      idle(4);
      chk(exp_q.size() == 0, "R5 all bytes delivered", exp_q.size(), 0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule